// File: doc/BRIEF.md
# Synchronous Serial Transfer Unit

The unit moves 8-bit frames between a host register interface and a three-wire clocked serial link. Bits go out most significant first. The host writes bytes into a transmit holding register, which sits in front of a shift register. Received bytes land in a receive holding register. The host paces itself through four status flags:

- transmit-empty
- transmit-done
- receive-full
- overrun

Register accesses set and clear these flags as side effects.

The unit can run as clock master or as slave. As master, it divides the system clock by `CLK_DIV` and drives `sck_o`. As slave, it follows `sck_i` only while `cs_ni` is low. In both modes the serial clock idles high. Output data changes after a falling edge, and input data is sampled on a rising edge. Reception stays off until the host enables it and then reads the receive register once as a dummy read. A receive interrupt request follows the receive-full flag when the host has enabled it.

Top module: `ss_serial_top`

## Requirements
- R1: A byte written to the transmit register is not shifted out, and `sck_o` stays high, while transmit enable (control bit 0) is 0. Once the bit is set, the byte is sent.
- R2: A write to the transmit register (address 2) clears transmit-empty (status bit 0) in the next cycle.
- R3: At the first falling edge of a frame, the pending byte moves into the shift register and transmit-empty returns to 1. If no byte is pending, all ones are shifted.
- R4: A byte written while the previous byte is still shifting goes out in the following frame, and transmit-done stays 0 in between.
- R5: Transmit-done (status bit 1) is set when a frame ends with transmit enabled and no byte pending. Writing 0 to status bit 1 clears it, and writing 1 has no effect.
- R6: A received frame is stored only after receive enable (control bit 1) is 1 and the host has read the receive register (address 3) since then. Clearing receive enable disarms reception. As master with receive on and transmit off, the unit clocks frames while armed and receive-full is 0, sending all ones.
- R7: In slave mode (control bit 3 = 0), the unit shifts only while `cs_ni` is low. `sck_i`, `cs_ni` and `sdi_i` each pass through a two-flop synchronizer, so a frame completes on the third clock edge after the eighth rising edge of `sck_i`.
- R8: A completed frame is stored in the receive register and sets receive-full (status bit 2). `rx_irq_o` is high while receive-full is 1 and interrupt enable (control bit 2) is 1.
- R9: Reading the receive register clears receive-full. If that read falls in the same cycle as a frame completion, the new byte is stored, receive-full stays 1, and no overrun is recorded.
- R10: In master mode (control bit 3 = 1), `sck_oe_o` is 1 and `sck_o` has a period of `CLK_DIV` clocks, idling high. Frames that follow one another keep that period.
- R11: A frame that completes while receive-full is 1, with no concurrent read, is dropped and sets overrun (status bit 3). Overrun clears only when 0 is written to status bit 3.
- R12: After reset, the control register (address 0) reads 0, the status register (address 1) reads 0x01, and `sck_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 transmit, 3 receive |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effects on receive register) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on addr_i |
| rx_irq_o | output | 1 | Receive interrupt request |
| sck_i | input | 1 | Serial clock input in slave mode |
| cs_ni | input | 1 | Slave select, active low |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock out in master mode, idle high |
| sck_oe_o | output | 1 | Serial clock output enable (master mode) |
| sdo_o | output | 1 | Serial data out |

## Verification
Two events can land in the same clock cycle: completion of a received frame, and a host read of the receive register. The bench controls the slave clock and knows the synchronizer latency. It uses that to place the read exactly on the completion cycle. It then repeats the case with the read one cycle late. Aligned, the new byte must be kept, receive-full must stay 1 and overrun must stay 0, while the read returns the previous byte. One cycle late, the frame must be dropped and overrun set, and the read returns the older byte and empties the register.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TXD  = 2'd2,
    REG_RXD  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic master;
    logic rie;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  typedef struct packed {
    logic ovr;
    logic rdf;
    logic tend;
    logic tde;
  } stat_t;
endpackage

// File: rtl/ss_clkgen.sv
module ss_clkgen #(
  parameter int CLK_DIV = 8,
  parameter int SYNC_W  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic run_i,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic sdi_i,
  output logic fall_o,
  output logic rise_o,
  output logic sel_o,
  output logic sdi_o,
  output logic sck_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [SYNC_W:0]   sck_s;
  logic [SYNC_W-1:0] cs_s;
  logic [SYNC_W-1:0] sdi_s;
  logic [CW-1:0]     cnt_q;
  logic              sck_q;
  logic              mrun, tick;

  assign mrun = master_i & run_i;
  assign tick = mrun & (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s <= '1;
      cs_s  <= '1;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[SYNC_W-1:0], sck_i};
      cs_s  <= {cs_s[SYNC_W-2:0], cs_ni};
      sdi_s <= {sdi_s[SYNC_W-2:0], sdi_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!mrun) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fall_o = master_i ? (tick & sck_q)  : (sck_s[SYNC_W] & ~sck_s[SYNC_W-1]);
  assign rise_o = master_i ? (tick & ~sck_q) : (~sck_s[SYNC_W] & sck_s[SYNC_W-1]);
  assign sel_o  = master_i | ~cs_s[SYNC_W-1];
  assign sdi_o  = sdi_s[SYNC_W-1];
  assign sck_o  = sck_q;
endmodule

// File: rtl/ss_shifter.sv
module ss_shifter #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fall_i,
  input  logic          rise_i,
  input  logic          sel_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] load_i,
  output logic          begin_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o,
  output logic          sdo_o,
  output logic          busy_o
);
  localparam int BW = (DW > 2) ? $clog2(DW) : 1;

  logic [DW-1:0] sh_q, rxsh_q, src;
  logic [BW-1:0] cnt_q;
  logic          busy_q, out_q, last;

  assign src     = busy_q ? sh_q : load_i;
  assign last    = (cnt_q == BW'(DW - 1));
  assign rx_o    = {rxsh_q[DW-2:0], sdi_i};
  assign begin_o = sel_i & fall_i & ~busy_q;
  assign done_o  = sel_i & rise_i & busy_q & last;
  assign sdo_o   = out_q;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      rxsh_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      out_q  <= 1'b1;
    end else if (!sel_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (fall_i) begin
        sh_q   <= {src[DW-2:0], 1'b1};
        out_q  <= src[DW-1];
        busy_q <= 1'b1;
      end
      if (rise_i && busy_q) begin
        rxsh_q <= rx_o;
        if (last) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ss_regs.sv
module ss_regs
  import ss_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          begin_i,
  input  logic          done_i,
  input  logic [DW-1:0] rx_i,
  output ctrl_t         ctrl_o,
  output stat_t         stat_o,
  output logic [DW-1:0] rdr_o,
  output logic [DW-1:0] load_o,
  output logic          start_o,
  output logic          irq_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] tdr_q, rdr_q;
  logic          tde_q, tend_q, rdf_q, ovr_q, armed_q;
  logic          wr_ctrl, wr_stat, wr_tdr, rd_rdr;
  logic          tx_live, tend_set, rx_store;

  assign wr_ctrl  = wr_i & (addr_i == REG_CTRL);
  assign wr_stat  = wr_i & (addr_i == REG_STAT);
  assign wr_tdr   = wr_i & (addr_i == REG_TXD);
  assign rd_rdr   = rd_i & (addr_i == REG_RXD);
  assign tx_live  = ctrl_q.tx_en & ~tde_q;
  assign tend_set = done_i & ctrl_q.tx_en & tde_q & ~wr_tdr;
  assign rx_store = done_i & ctrl_q.rx_en & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      tdr_q   <= '0;
      rdr_q   <= '0;
      tde_q   <= 1'b1;
      tend_q  <= 1'b0;
      rdf_q   <= 1'b0;
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[3:0]);

      if (!ctrl_q.rx_en) armed_q <= 1'b0;
      else if (rd_rdr)   armed_q <= 1'b1;

      if (begin_i && tx_live) tde_q <= 1'b1;
      if (wr_tdr) begin
        tdr_q <= wdata_i;
        tde_q <= 1'b0;
      end

      if (wr_stat && !wdata_i[1]) tend_q <= 1'b0;
      if (tend_set)               tend_q <= 1'b1;

      if (wr_stat && !wdata_i[3]) ovr_q <= 1'b0;
      if (rd_rdr)                 rdf_q <= 1'b0;
      if (rx_store) begin
        if (rdf_q && !rd_rdr) begin
          ovr_q <= 1'b1;  // byte dropped
        end else begin
          rdr_q <= rx_i;
          rdf_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: rdata_o[3:0] = ctrl_q;
      REG_STAT: rdata_o[3:0] = {ovr_q, rdf_q, tend_q, tde_q};
      REG_TXD:  rdata_o      = tdr_q;
      REG_RXD:  rdata_o      = rdr_q;
      default:  rdata_o      = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign stat_o  = '{ovr: ovr_q, rdf: rdf_q, tend: tend_q, tde: tde_q};
  assign rdr_o   = rdr_q;
  assign load_o  = tx_live ? tdr_q : '1;
  assign start_o = ctrl_q.master &
                   (tx_live | (ctrl_q.rx_en & armed_q & ~ctrl_q.tx_en & ~rdf_q));
  assign irq_o   = ctrl_q.rie & rdf_q;
endmodule

// File: rtl/ss_serial_top.sv
module ss_serial_top
  import ss_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int DW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rx_irq_o,
  input  logic          sck_i,
  input  logic          cs_ni,
  input  logic          sdi_i,
  output logic          sck_o,
  output logic          sck_oe_o,
  output logic          sdo_o
);
  ctrl_t         ctrl_w;
  stat_t         stat_w;
  logic [3:0]    stat_bits;
  logic [DW-1:0] rdr_w, load_w, rx_w;
  logic          start_w, busy_w, fall_w, rise_w, sel_w, sdi_w;
  logic          begin_w, done_w;

  assign stat_bits = stat_w;
  assign sck_oe_o  = ctrl_w.master;

  ss_clkgen #(.CLK_DIV(CLK_DIV), .SYNC_W(2)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (ctrl_w.master),
    .run_i    (start_w | busy_w),
    .sck_i    (sck_i),
    .cs_ni    (cs_ni),
    .sdi_i    (sdi_i),
    .fall_o   (fall_w),
    .rise_o   (rise_w),
    .sel_o    (sel_w),
    .sdi_o    (sdi_w),
    .sck_o    (sck_o)
  );

  ss_shifter #(.DW(DW)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (fall_w),
    .rise_i  (rise_w),
    .sel_i   (sel_w),
    .sdi_i   (sdi_w),
    .load_i  (load_w),
    .begin_o (begin_w),
    .done_o  (done_w),
    .rx_o    (rx_w),
    .sdo_o   (sdo_o),
    .busy_o  (busy_w)
  );

  ss_regs #(.DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .begin_i (begin_w),
    .done_i  (done_w),
    .rx_i    (rx_w),
    .ctrl_o  (ctrl_w),
    .stat_o  (stat_w),
    .rdr_o   (rdr_w),
    .load_o  (load_w),
    .start_o (start_w),
    .irq_o   (rx_irq_o)
  );
endmodule

// File: rtl/ss_serial_chk.sv
module ss_serial_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    addr_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [3:0]    stat_i,
  input logic [DW-1:0] rdr_i,
  input logic          done_i
);
  // R2
  tde_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2) |=> !stat_i[0]);

  // R5
  tend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[1]) |-> ($past(done_i) && $past(stat_i[0])));

  // R8
  rdf_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[2]) |-> $past(done_i));

  // R9
  rdf_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd3 && !done_i) |=> !stat_i[2]);

  // R11
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[3]) |-> ($past(stat_i[2]) && $stable(rdr_i)));
endmodule

bind ss_serial_top ss_serial_chk #(.DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .stat_i (stat_bits),
  .rdr_i  (rdr_w),
  .done_i (done_w)
);

// File: tb/sim_ss_serial_top.sv
module sim_ss_serial_top;
  localparam int CLK_DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, sck_o, sck_oe, sdo;
  logic       tb_sck = 1'b1, tb_cs = 1'b1, tb_sdi = 1'b0;
  logic       sdi_w;
  int         n_chk = 0, n_fail = 0;
  bit         fin = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign sdi_w = sck_oe ? sdo : tb_sdi;  // loopback as master

  ss_serial_top #(.CLK_DIV(CLK_DIV), .DW(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_irq_o(irq),
    .sck_i(tb_sck), .cs_ni(tb_cs), .sdi_i(sdi_w),
    .sck_o(sck_o), .sck_oe_o(sck_oe), .sdo_o(sdo)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_stat(input int b, input logic v, input string tag);
    logic [7:0] s;
    bit ok = 1'b0;
    for (int k = 0; k < 400; k++) begin
      host_rd(2'd1, s);
      if (s[b] == v) begin ok = 1'b1; break; end
    end
    chk(ok, tag, 32'(s[b]), 32'(v));
  endtask

  task automatic slave_frame(input logic [7:0] s, input int rdmode,
                             output logic [7:0] got, output logic [7:0] rv);
    rv = '0;
    tb_cs = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); tb_sck = 1'b0; tb_sdi = s[7-i];
      repeat (8) @(negedge clk);
      got[7-i] = sdo;
      tb_sck = 1'b1;
      if (i == 7 && rdmode != 0) begin
        @(negedge clk);
        if (rdmode == 2) @(negedge clk);
        host_rd(2'd3, rv);
      end
      repeat (8) @(negedge clk);
    end
    tb_cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got, rv;
    int n;
    bit quiet;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    host_rd(2'd0, d); chk(d == 8'h00, "R12 ctrl reset", d, 8'h00);
    host_rd(2'd1, d); chk(d == 8'h01, "R12 stat reset", d, 8'h01);
    chk(sck_o == 1'b1, "R12 sck idle", sck_o, 1);
    chk(irq == 1'b0, "R8 irq reset", irq, 0);

    // transmit held off while disabled
    host_wr(2'd0, 8'h08);
    host_wr(2'd2, 8'h5A);
    host_rd(2'd1, d); chk(d[0] == 1'b0, "R2 tde cleared", d[0], 0);
    quiet = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); if (!sck_o) quiet = 1'b0;
    end
    chk(quiet, "R1 no clock while disabled", !quiet, 0);
    host_rd(2'd1, d); chk(d[0] == 1'b0, "R1 byte held", d[0], 0);
    host_wr(2'd0, 8'h09);
    wait_stat(0, 1'b1, "R3 tde set at load");
    wait_stat(1, 1'b1, "R5 tend after frame");
    host_rd(2'd1, d); chk(d[2] == 1'b0, "R6 no store while rx off", d[2], 0);

    // receive enabled but not armed
    host_wr(2'd0, 8'h0B);
    host_wr(2'd1, 8'h0A);
    host_rd(2'd1, d); chk(d[1] == 1'b1, "R5 write 1 keeps tend", d[1], 1);
    host_wr(2'd1, 8'h00);
    host_rd(2'd1, d); chk(d[1] == 1'b0, "R5 tend cleared", d[1], 0);
    host_wr(2'd2, 8'h3C);
    wait_stat(1, 1'b1, "R5 tend unarmed frame");
    host_rd(2'd1, d); chk(d[2] == 1'b0, "R6 unarmed no store", d[2], 0);

    // dummy read arms
    host_rd(2'd3, d);
    host_wr(2'd0, 8'h0F);
    host_wr(2'd2, 8'hC3);
    wait_stat(2, 1'b1, "R8 rdf after frame");
    chk(irq == 1'b1, "R8 irq raised", irq, 1);
    host_rd(2'd3, d); chk(d == 8'hC3, "R8 rx data", d, 8'hC3);
    host_rd(2'd1, d); chk(d[2] == 1'b0, "R9 rdf cleared by read", d[2], 0);
    chk(irq == 1'b0, "R9 irq drops", irq, 0);

    // master clock period
    host_wr(2'd2, 8'hA5);
    chk(sck_oe == 1'b1, "R10 clock driven", sck_oe, 1);
    n = 0;
    while (sck_o && n < 200) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!sck_o && n < 200);
    do begin @(negedge clk); n++; end while (sck_o && n < 200);
    chk(n == CLK_DIV, "R10 sck period", n, CLK_DIV);
    wait_stat(2, 1'b1, "R10 frame done");
    host_rd(2'd3, d); chk(d == 8'hA5, "R10 loopback", d, 8'hA5);

    // all byte values through loopback
    for (int v = 0; v < 256; v++) begin
      host_wr(2'd2, 8'(v));
      wait_stat(2, 1'b1, "R8 sweep rdf");
      host_rd(2'd3, d); chk(d == 8'(v), "R8 sweep data", d, v);
    end

    // back-to-back
    host_wr(2'd1, 8'h00);
    host_wr(2'd2, 8'h11);
    wait_stat(0, 1'b1, "R3 first loaded");
    host_wr(2'd2, 8'h22);
    wait_stat(2, 1'b1, "R4 first received");
    host_rd(2'd1, d); chk(d[1] == 1'b0, "R4 tend held", d[1], 0);
    host_rd(2'd3, d); chk(d == 8'h11, "R4 first byte", d, 8'h11);
    wait_stat(2, 1'b1, "R4 second received");
    host_rd(2'd1, d); chk(d[1] == 1'b1, "R5 tend at end", d[1], 1);
    host_rd(2'd3, d); chk(d == 8'h22, "R4 second byte", d, 8'h22);

    // overrun
    host_wr(2'd1, 8'h00);
    host_wr(2'd2, 8'h44);
    wait_stat(0, 1'b1, "R3 loaded");
    host_wr(2'd2, 8'h55);
    wait_stat(1, 1'b1, "R11 tend");
    host_rd(2'd1, d); chk(d[3:2] == 2'b11, "R11 ovr and rdf", d[3:2], 3);
    host_rd(2'd3, d); chk(d == 8'h44, "R11 old byte kept", d, 8'h44);
    host_wr(2'd1, 8'h02);
    host_rd(2'd1, d); chk(d[3:1] == 3'b001, "R11 ovr cleared", d[3:1], 1);

    // master receive-only
    host_wr(2'd0, 8'h0A);
    host_rd(2'd3, d);
    wait_stat(2, 1'b1, "R6 rx-only frame");
    host_rd(2'd3, d); chk(d == 8'hFF, "R6 rx-only data", d, 8'hFF);
    host_wr(2'd0, 8'h00);

    // slave mode
    host_wr(2'd1, 8'h00);
    host_wr(2'd0, 8'h07);
    host_rd(2'd3, d);
    chk(sck_oe == 1'b0, "R7 clock not driven", sck_oe, 0);
    host_wr(2'd2, 8'h99);
    for (int k = 0; k < 8; k++) begin
      repeat (6) @(negedge clk); tb_sck = 1'b0;
      repeat (6) @(negedge clk); tb_sck = 1'b1;
    end
    repeat (6) @(negedge clk);
    host_rd(2'd1, d); chk(d[2:0] == 3'b000, "R7 ignored while deselected", d[2:0], 0);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] t, s;
      t = (i == 0) ? 8'h99 : 8'(i * 37 + 5);
      s = 8'(i * 29 + 8'h40);
      if (i != 0) host_wr(2'd2, t);
      slave_frame(s, 0, got, rv);
      chk(got == t, "R7 slave tx msb first", got, t);
      chk(irq == 1'b1, "R8 slave irq", irq, 1);
      host_rd(2'd3, d); chk(d == s, "R7 slave rx", d, s);
    end

    // completion and read in one cycle
    slave_frame(8'h12, 0, got, rv);
    slave_frame(8'h34, 1, got, rv);
    chk(rv == 8'h12, "R9 aligned read old", rv, 8'h12);
    host_rd(2'd1, d); chk(d[3:2] == 2'b01, "R9 aligned keeps new", d[3:2], 1);
    host_rd(2'd3, d); chk(d == 8'h34, "R9 aligned new byte", d, 8'h34);
    slave_frame(8'h56, 0, got, rv);
    slave_frame(8'h78, 2, got, rv);
    chk(rv == 8'h56, "R11 late read old", rv, 8'h56);
    host_rd(2'd1, d); chk(d[3:2] == 2'b10, "R11 late overrun", d[3:2], 2);
    host_rd(2'd3, d); chk(d == 8'h56, "R11 dropped frame", d, 8'h56);

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule